// File: doc/BRIEF.md
# Triggered Command Queue Controller

This block holds conversion command words that software has pushed and releases them, oldest first, to a downstream converter over a valid/ready transfer port. A 16-bit control register decides when the queue may drain. Its mode field selects the release condition. The queue can be disabled. It can run a software-started single scan. It can also run a single scan that proceeds only while an external trigger level is low, or only while that level is high. Two write-only action bits sit in the same register. One arms a single scan. The other flushes everything still queued.

A scan starts when software writes the arm bit in a scan mode. It ends when the transfer port takes the last queued entry, or when software writes the mode back to disabled. Illegal mode writes are refused and recorded in a sticky flag. Pushes into a full queue are dropped and recorded in a sticky overflow flag. The trigger input is asynchronous and passes through a two-stage synchronizer before it gates transfers.

Top module: `cmdq_trig_ctrl`

## Requirements
- R1: After a synchronous active-low reset the mode is disabled, the register reads 0, the queue is empty, the scan is not armed, both sticky flags are 0 and xfer_valid is 0.
- R2: cfg_rdata carries the mode in bits [7:4] (bit 0 = LSB) and 0 in every other bit. The arm bit (bit 10) and the invalidate bit (bit 9) always read 0.
- R3: A push is stored when fewer than 4 entries are held. A push when 4 entries are held is dropped and sets the sticky overflow flag, even if a transfer takes place in the same cycle. Entries leave in the order they were pushed.
- R4: Mode codes are 0 = disabled, 1 = software single scan, 2 = single scan gated by a low trigger, 3 = single scan gated by a high trigger. Codes 4 to 15 are refused: the mode is kept and illegal_wr is set.
- R5: When the mode is not 0, a write may only leave it unchanged or set it to 0. A change from 0 to 1, 2 or 3 is accepted only when no scan is armed. A refused write keeps the old mode and sets the sticky illegal_wr flag.
- R6: Writing 1 to bit 10 arms the scan when the mode in force after that write is 1, 2 or 3. The write does nothing in mode 0 or while already armed. Writing 0 to bit 10 does nothing.
- R7: xfer_valid is 1 exactly when the scan is armed, the queue is not empty, and the gate is open. The gate is always open in mode 1, open on a low synchronized trigger in mode 2, and open on a high synchronized trigger in mode 3. xfer_data is then the oldest entry. A cycle with xfer_valid and xfer_ready removes it.
- R8: A change on trig_in reaches the gate after two rising clock edges.
- R9: The armed flag clears when a transfer takes the only held entry and no push is stored in that cycle, or when the mode is set to 0.
- R10: Writing 1 to bit 9 empties the queue and sets both pointers back to the first slot, so the next stored push is the next entry transferred. A push in the same cycle is discarded without setting overflow. A transfer completing in that cycle still completes. The armed flag is unchanged. If a scan was armed, illegal_wr is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read value |
| cmd_push | input | 1 | Push strobe for a command word |
| cmd_data | input | 32 | Command word to push |
| xfer_valid | output | 1 | Oldest entry offered downstream |
| xfer_ready | input | 1 | Downstream accepts the offered entry |
| xfer_data | output | 32 | Oldest queued command word |
| trig_in | input | 1 | Asynchronous external trigger level |
| q_level | output | 3 | Number of entries held |
| scan_armed | output | 1 | Single scan armed (queue not idle) |
| illegal_wr | output | 1 | Sticky flag for refused or unsafe writes |
| overflow | output | 1 | Sticky flag for dropped pushes |

## Verification
The hardest state to reach is a gated scan that pauses partway through. The queue has to be armed with entries left, and the trigger has to fall while a handshake is still in flight behind the two-stage synchronizer. The stimulus gets there by filling the queue with the trigger inactive and arming it. It then raises the trigger, counts the two-edge latency, and drops the trigger after one transfer. Two more entries still leave before the pause can be seen. A long random phase then mixes pushes, stalls, trigger toggles, refused mode codes and flushes during armed scans. All of it is compared every cycle against a behavioural queue model.

// File: rtl/cmdq_pkg.sv
// Package: shared constants and the mode type for the triggered command queue.
// Bit indices are LSB-numbered positions inside the 16-bit control word.
package cmdq_pkg;
    localparam int CFG_W   = 16;
    localparam int ARM_IDX = 10;
    localparam int INV_IDX = 9;
    localparam int MODE_LO = 4;
    localparam int MODE_W  = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF     = 4'd0,
        MODE_SW      = 4'd1,
        MODE_GATE_LO = 4'd2,
        MODE_GATE_HI = 4'd3
    } qmode_e;

    localparam logic [MODE_W-1:0] MODE_MAX = 4'd3;
endpackage

// File: rtl/cmdq_sync.sv
// Module: multi-stage level synchronizer for the asynchronous trigger input.
// Assumes: STAGES >= 2; output is the input delayed by STAGES rising edges.
module cmdq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmdq_fifo.sv
// Module: circular command store with push/transfer pointers and a level counter.
// Assumes: the caller issues wr_en only when not full (judged before any read)
// and rd_en only when not empty; flush overrides both and rewinds the pointers.
module cmdq_fifo #(
    parameter  int DEPTH  = 4,
    parameter  int DATA_W = 32,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              flush,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  push_ptr;
    logic [PTR_W-1:0]  take_ptr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Store the pushed word in the slot the push pointer names.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            slots[push_ptr] <= wr_data;
        end
    end

    // Advance or rewind the pointers and track the number of held entries.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            push_ptr <= '0;
            take_ptr <= '0;
            count    <= '0;
        end else begin
            if (wr_en) begin
                push_ptr <= ptr_inc(push_ptr);
            end
            if (rd_en) begin
                take_ptr <= ptr_inc(take_ptr);
            end
            count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    assign rd_data = slots[take_ptr];
endmodule

// File: rtl/cmdq_cfg.sv
// Module: control register holding the mode, the armed flag and the illegal-write flag.
// Assumes: scan_end is asserted by the caller in the cycle a transfer takes the
// last held entry with no push stored; the action bits act only on cfg_we.
module cmdq_cfg
    import cmdq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             scan_end,
    output qmode_e           mode,
    output logic             armed,
    output logic             illegal,
    output logic             flush,
    output logic [CFG_W-1:0] rd_word
);
    logic [MODE_W-1:0] req_mode;
    logic              mode_ok;
    qmode_e            mode_nx;
    logic              arm_req;
    logic              armed_nx;
    logic              refuse;
    logic              unused_bits;

    assign req_mode    = cfg_wdata[MODE_LO +: MODE_W];
    assign arm_req     = cfg_we && cfg_wdata[ARM_IDX];
    assign flush       = cfg_we && cfg_wdata[INV_IDX];
    assign unused_bits = ^{cfg_wdata[CFG_W-1:ARM_IDX+1], cfg_wdata[INV_IDX-1:MODE_LO+MODE_W],
                           cfg_wdata[MODE_LO-1:0]};

    // Decide whether the requested mode obeys the transition rule.
    always_comb begin
        mode_ok = (req_mode == mode) || (req_mode == MODE_OFF) ||
                  ((mode == MODE_OFF) && !armed && (req_mode <= MODE_MAX));
    end

    // Select the mode in force after this cycle's write.
    always_comb begin
        mode_nx = mode;
        if (cfg_we && mode_ok) begin
            mode_nx = qmode_e'(req_mode);
        end
    end

    // Flag a refused mode or a flush requested in the middle of a scan.
    always_comb begin
        refuse = cfg_we && (!mode_ok || (cfg_wdata[INV_IDX] && armed));
    end

    // Arm on request only when idle in a scan mode; disarm at scan end or disable.
    always_comb begin
        if (mode_nx == MODE_OFF) begin
            armed_nx = 1'b0;
        end else if (armed) begin
            armed_nx = !scan_end;
        end else begin
            armed_nx = arm_req;
        end
    end

    // Register the mode, the armed flag and the sticky illegal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_OFF;
            armed   <= 1'b0;
            illegal <= 1'b0;
        end else begin
            mode    <= mode_nx;
            armed   <= armed_nx;
            illegal <= illegal || refuse;
        end
    end

    // Compose the read value: mode field only, action and reserved bits as zero.
    always_comb begin
        rd_word = '0;
        rd_word[MODE_LO +: MODE_W] = mode;
    end
endmodule

// File: rtl/cmdq_trig_ctrl.sv
// Module: top of the triggered command queue. Combines the command store, the
// control register and the trigger synchronizer, and drives the transfer port.
// Assumes: cmd_push is a one-cycle strobe per word; trig_in may be asynchronous.
module cmdq_trig_ctrl
    import cmdq_pkg::*;
#(
    parameter  int DEPTH     = 4,
    parameter  int DATA_W    = 32,
    parameter  int SYNC_STGS = 2,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              cmd_push,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [DATA_W-1:0] xfer_data,
    input  logic              trig_in,
    output logic [CNT_W-1:0]  q_level,
    output logic              scan_armed,
    output logic              illegal_wr,
    output logic              overflow
);
    qmode_e mode;
    logic   trig_s;
    logic   flush;
    logic   gate_open;
    logic   take;
    logic   full;
    logic   store;
    logic   scan_end;

    cmdq_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (trig_in),
        .q_sync  (trig_s)
    );

    cmdq_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .scan_end  (scan_end),
        .mode      (mode),
        .armed     (scan_armed),
        .illegal   (illegal_wr),
        .flush     (flush),
        .rd_word   (cfg_rdata)
    );

    cmdq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .wr_data (cmd_data),
        .rd_en   (take),
        .flush   (flush),
        .rd_data (xfer_data),
        .count   (q_level)
    );

    // Open the release gate according to the mode and the synchronized trigger.
    always_comb begin
        unique case (mode)
            MODE_SW:      gate_open = 1'b1;
            MODE_GATE_LO: gate_open = !trig_s;
            MODE_GATE_HI: gate_open = trig_s;
            default:      gate_open = 1'b0;
        endcase
    end

    // Offer the head entry and form the push, pop and scan-end strobes.
    always_comb begin
        xfer_valid = scan_armed && (q_level != '0) && gate_open;
        take       = xfer_valid && xfer_ready;
        full       = (q_level == CNT_W'(DEPTH));
        store      = cmd_push && !full && !flush;
        scan_end   = take && (q_level == CNT_W'(1)) && !store;
    end

    // Hold the sticky overflow flag for pushes dropped at a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (cmd_push && full && !flush) begin
            overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/cmdq_trig_ctrl_chk.sv
// Module: property checker for the triggered command queue, bound to the top.
// Assumes: signals are sampled at the rising clock edge; reset is synchronous.
module cmdq_trig_ctrl_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_inv,
    input logic [3:0]       mode_rd,
    input logic             cmd_push,
    input logic             xfer_valid,
    input logic             xfer_ready,
    input logic [CNT_W-1:0] q_level,
    input logic             scan_armed,
    input logic             illegal_wr,
    input logic             overflow
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (q_level == '0 && !scan_armed && !illegal_wr && !overflow && mode_rd == 4'd0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= CNT_W'(DEPTH));

    p_full_push_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_push && q_level == CNT_W'(DEPTH) && !(cfg_we && cfg_inv)) |=> overflow);

    p_mode_supported_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd <= 4'd3);

    p_mode_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd != 4'd0 |=> (mode_rd == $past(mode_rd) || mode_rd == 4'd0));

    p_sticky_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_wr |=> illegal_wr);

    p_disabled_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd == 4'd0 |-> !scan_armed);

    p_valid_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (scan_armed && q_level != '0));

    p_scan_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ready && q_level == CNT_W'(1) && !cmd_push) |=> !scan_armed);

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_inv) |=> q_level == '0);
endmodule

bind cmdq_trig_ctrl cmdq_trig_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_inv    (cfg_wdata[9]),
    .mode_rd    (cfg_rdata[7:4]),
    .cmd_push   (cmd_push),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .q_level    (q_level),
    .scan_armed (scan_armed),
    .illegal_wr (illegal_wr),
    .overflow   (overflow)
);

// File: tb/cmdq_trig_ctrl_tb.sv
// Bench: behavioural queue model updated on every rising edge and compared
// with all outputs one nanosecond later; directed phases then a random phase.
module cmdq_trig_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cmd_push = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        xfer_valid;
    logic        xfer_ready = 1'b0;
    logic [31:0] xfer_data;
    logic        trig_in = 1'b0;
    logic [2:0]  q_level;
    logic        scan_armed;
    logic        illegal_wr;
    logic        overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state.
    logic [31:0] m_q[$];
    int m_mode = 0;
    bit m_armed = 0, m_ill = 0, m_ovf = 0, m_t1 = 0, m_t2 = 0;

    always #2 clk = ~clk;

    cmdq_trig_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cmd_push(cmd_push), .cmd_data(cmd_data),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_data(xfer_data),
        .trig_in(trig_in), .q_level(q_level), .scan_armed(scan_armed),
        .illegal_wr(illegal_wr), .overflow(overflow)
    );

    function automatic bit exp_valid();
        bit g;
        case (m_mode)
            1: g = 1'b1;
            2: g = !m_t2;
            3: g = m_t2;
            default: g = 1'b0;
        endcase
        return m_armed && (m_q.size() > 0) && g;
    endfunction

    // Model update at each rising edge from pre-edge state and inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_mode = 0; m_armed = 0; m_ill = 0; m_ovf = 0; m_t1 = 0; m_t2 = 0;
        end else begin
            bit hs, full, inv, arm, legal, push_ok, scan_end;
            int cnt, wm, nm;
            cnt  = m_q.size();
            hs   = exp_valid() && xfer_ready;
            full = (cnt == 4);
            inv  = cfg_we && cfg_wdata[9];
            arm  = cfg_we && cfg_wdata[10];
            nm   = m_mode;
            if (cfg_we) begin
                wm = int'(cfg_wdata[7:4]);
                legal = (wm == m_mode) || (wm == 0) || (m_mode == 0 && !m_armed && wm <= 3);
                if (legal) nm = wm; else m_ill = 1;
                if (inv && m_armed) m_ill = 1;
            end
            push_ok = cmd_push && !full && !inv;
            if (cmd_push && full && !inv) m_ovf = 1;
            scan_end = hs && cnt == 1 && !push_ok;
            if (hs) void'(m_q.pop_front());
            if (inv) m_q.delete();
            else if (push_ok) m_q.push_back(cmd_data);
            if (nm == 0) m_armed = 0;
            else if (m_armed) m_armed = !scan_end;
            else m_armed = arm;
            m_mode = nm;
            m_t2 = m_t1;
            m_t1 = trig_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        bit ev;
        ev = exp_valid();
        check("R2 cfg_rdata", {16'h0, cfg_rdata}, {16'h0, 8'h0, 4'(m_mode), 4'h0});
        check("R3 q_level", {29'h0, q_level}, m_q.size());
        check("R3 overflow", {31'h0, overflow}, {31'h0, m_ovf});
        check("R5 illegal_wr", {31'h0, illegal_wr}, {31'h0, m_ill});
        check("R6 scan_armed", {31'h0, scan_armed}, {31'h0, m_armed});
        check("R7 xfer_valid", {31'h0, xfer_valid}, {31'h0, ev});
        if (ev) check("R7 xfer_data", xfer_data, m_q[0]);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        compare_all();
        cfg_we = 1'b0;
        cmd_push = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [31:0] d);
        cmd_push = 1'b1; cmd_data = d; tick();
    endtask

    task automatic wcfg(input logic [15:0] w);
        cfg_we = 1'b1; cfg_wdata = w; tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 level", {29'h0, q_level}, 0);
        check("R1 armed", {31'h0, scan_armed}, 0);
        check("R1 flags", {30'h0, illegal_wr, overflow}, 0);
        check("R1 rdata", {16'h0, cfg_rdata}, 0);
        check("R1 valid", {31'h0, xfer_valid}, 0);

        // Software single scan.
        xfer_ready = 1'b1;
        push(32'hA0); push(32'hA1); push(32'hA2);
        check("R3 three held", {29'h0, q_level}, 3);
        check("R7 disabled holds", {31'h0, xfer_valid}, 0);
        wcfg(16'h0400);
        check("R6 arm ignored in mode 0", {31'h0, scan_armed}, 0);
        wcfg(16'h0010);
        check("R2 mode readback", {16'h0, cfg_rdata}, 32'h0010);
        check("R6 not armed by mode write", {31'h0, scan_armed}, 0);
        wcfg(16'h0410);
        check("R6 armed", {31'h0, scan_armed}, 1);
        check("R7 head A0", xfer_data, 32'hA0);
        tick(); check("R7 head A1", xfer_data, 32'hA1);
        tick(); check("R7 head A2", xfer_data, 32'hA2);
        tick();
        check("R9 scan end disarms", {31'h0, scan_armed}, 0);
        check("R9 queue empty", {29'h0, q_level}, 0);

        // Overflow and order.
        xfer_ready = 1'b0;
        for (int i = 0; i < 5; i++) push(32'hB0 + i);
        check("R3 full level", {29'h0, q_level}, 4);
        check("R3 overflow set", {31'h0, overflow}, 1);
        wcfg(16'h0410);
        wcfg(16'h0410);
        xfer_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check("R3 order", xfer_data, 32'hB0 + i);
            tick();
        end
        check("R9 drained", {31'h0, scan_armed}, 0);
        wcfg(16'h0000);

        // R4: unsupported codes.
        do_reset();
        wcfg(16'h0050);
        check("R4 code 5 refused", {16'h0, cfg_rdata}, 0);
        check("R4 illegal set", {31'h0, illegal_wr}, 1);
        wcfg(16'h00F0);
        check("R4 code 15 refused", {16'h0, cfg_rdata}, 0);

        // R5: transition rule.
        do_reset();
        wcfg(16'h0030);
        check("R5 0->3 accepted", {16'h0, cfg_rdata}, 32'h0030);
        check("R5 no flag", {31'h0, illegal_wr}, 0);
        wcfg(16'h0020);
        check("R5 3->2 refused", {16'h0, cfg_rdata}, 32'h0030);
        check("R5 flag set", {31'h0, illegal_wr}, 1);
        wcfg(16'h0000);
        check("R5 3->0 accepted", {16'h0, cfg_rdata}, 0);

        // R9: disable clears arm, then a new mode is accepted.
        do_reset();
        xfer_ready = 1'b0;
        wcfg(16'h0010); push(32'hC5); wcfg(16'h0410);
        check("R6 armed with entry", {31'h0, scan_armed}, 1);
        wcfg(16'h0000);
        check("R9 disable disarms", {31'h0, scan_armed}, 0);
        wcfg(16'h0020);
        check("R5 idle change ok", {16'h0, cfg_rdata}, 32'h0020);
        check("R5 no flag idle", {31'h0, illegal_wr}, 0);

        // R7/R8: high-gated scan with pause.
        do_reset();
        trig_in = 1'b0;
        for (int i = 0; i < 4; i++) push(32'hC0 + i);
        xfer_ready = 1'b1;
        wcfg(16'h0030); wcfg(16'h0430);
        tick(); tick();
        check("R7 gate closed", {31'h0, xfer_valid}, 0);
        check("R7 nothing taken", {29'h0, q_level}, 4);
        trig_in = 1'b1;
        tick();
        check("R8 one edge not yet", {31'h0, xfer_valid}, 0);
        tick();
        check("R8 two edges open", {31'h0, xfer_valid}, 1);
        check("R7 head C0", xfer_data, 32'hC0);
        tick();
        trig_in = 1'b0;
        tick(); tick(); tick(); tick();
        check("R7 paused level", {29'h0, q_level}, 1);
        check("R7 paused valid", {31'h0, xfer_valid}, 0);
        trig_in = 1'b1;
        tick(); tick();
        check("R7 resumed C3", xfer_data, 32'hC3);
        tick();
        check("R9 gated scan end", {31'h0, scan_armed}, 0);

        // Low-gated scan.
        wcfg(16'h0000); wcfg(16'h0020);
        push(32'hD0);
        wcfg(16'h0420);
        tick();
        check("R7 low gate closed", {31'h0, xfer_valid}, 0);
        trig_in = 1'b0;
        tick(); tick();
        check("R7 low gate open", {31'h0, xfer_valid}, 1);
        check("R7 head D0", xfer_data, 32'hD0);
        tick();

        // R10: invalidate.
        do_reset();
        xfer_ready = 1'b0;
        push(32'hE0); push(32'hE1); push(32'hE2);
        wcfg(16'h0200);
        check("R10 flushed", {29'h0, q_level}, 0);
        check("R10 idle flush no flag", {31'h0, illegal_wr}, 0);
        push(32'hE7);
        cmd_push = 1'b1; cmd_data = 32'hEE; cfg_we = 1'b1; cfg_wdata = 16'h0200; tick();
        check("R10 push discarded", {29'h0, q_level}, 0);
        check("R10 no overflow", {31'h0, overflow}, 0);
        push(32'hF0);
        xfer_ready = 1'b1;
        wcfg(16'h0010); wcfg(16'h0410);
        check("R10 pointers rewound", xfer_data, 32'hF0);
        tick();
        xfer_ready = 1'b0;
        push(32'hF1); push(32'hF2);
        wcfg(16'h0410);
        wcfg(16'h0210);
        check("R10 armed flush empties", {29'h0, q_level}, 0);
        check("R10 armed flush flags", {31'h0, illegal_wr}, 1);
        check("R10 arm kept", {31'h0, scan_armed}, 1);

        // Random phase.
        do_reset();
        for (int c = 0; c < 6000; c++) begin
            int r;
            logic [3:0] md;
            if (c % 1500 == 1499) begin
                do_reset();
            end else begin
                cmd_push   = ($urandom % 2) == 0;
                cmd_data   = $urandom;
                xfer_ready = ($urandom % 3) != 0;
                if (($urandom % 16) == 0) trig_in = ~trig_in;
                cfg_we = ($urandom % 10) == 0;
                r  = $urandom % 8;
                md = (r < 4) ? 4'(r) : 4'($urandom % 16);
                cfg_wdata = (16'($urandom) & 16'hF90F) | {4'h0, 1'b0, 1'($urandom % 2),
                            1'(($urandom % 8) == 0), 1'b0, md, 4'h0};
                tick();
            end
        end
        finish_run();
    end
endmodule